// File: doc/BRIEF.md
# Two-Lane DDR Sample Deserializer

This block takes the serial output of a 12-bit data converter that sends each sample over two data lanes with a word-marking frame line, and rebuilds one parallel sample per word. Both lanes and the frame line carry a new bit, called a slot, on every edge of the data clock. The block records the falling-edge slot and then the rising-edge slot. It finds word starts from transitions on the frame line and merges the two lanes odd/even into the 12-bit sample. The two extra flag bits that follow the data are delivered on their own outputs.

There are two word formats, chosen by a mode input. In the long format a word has eight slots per lane and the frame line runs at the sample rate. In the short format a word has seven slots per lane and the frame line runs at half the sample rate, so each frame transition opens a word. The block gives one valid pulse per word. It raises a one-cycle error pulse when the frame line disagrees with its slot count, or when the trailing pad slot of a long word is not zero.

Top module: `dlane_deser`

## Requirements
- R1: In a word, the lane A bit at slot k becomes sample bit 11-2k and the lane B bit at slot k becomes sample bit 10-2k, for k = 0..5. Slot 0 is the slot in which the word-start frame transition is seen.
- R2: The lane A bit at slot 6 is output on `dx_o` and the lane B bit at slot 6 on `dy_o`. Neither bit appears in `sample_o`.
- R3: With `mode14_i` = 0 a word is 8 slots, and only a low-to-high frame transition starts a word. A high-to-low transition in the middle of a word has no effect on the word's contents.
- R4: With `mode14_i` = 1 a word is 7 slots, and a frame transition in either direction starts a word.
- R5: Slots are taken on both data-clock edges, in time order. The slot seen at a falling edge comes before the slot seen at the next rising edge, and words decode the same whichever edge carries their slot 0.
- R6: After reset, no word is delivered and no error is raised until the first word-start frame transition. Lane data before that transition is ignored.
- R7: `valid_o` is high for exactly one clock per completed word. `sample_o`, `dx_o` and `dy_o` hold their values between words.
- R8: With `mode14_i` = 0, a 1 on either lane at slot 7 raises `err_o` for one clock together with that word's `valid_o`. The word is still delivered.
- R9: A word-start frame transition that arrives before the current word has all its slots raises `err_o` for one clock. The partial word is dropped and the transition begins a new word.
- R10: While `rst_n` is low, `valid_o` and `err_o` are 0 and `sample_o`, `dx_o`, `dy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; lanes and frame are sampled on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| mode14_i | input | 1 | 0 = 8-slot words, 1 = 7-slot words |
| lane_a_i | input | 1 | Serial lane carrying the odd data bits and the DX flag |
| lane_b_i | input | 1 | Serial lane carrying the even data bits and the DY flag |
| frame_i | input | 1 | Word-marking frame line |
| sample_o | output | 12 | Rebuilt sample |
| dx_o | output | 1 | Lane A flag bit of the word |
| dy_o | output | 1 | Lane B flag bit of the word |
| valid_o | output | 1 | One-clock strobe per completed word |
| err_o | output | 1 | One-clock strobe for a framing or padding fault |

## Verification
The same table of eight samples is streamed in both modes. The table includes all-ones, all-zeros, alternating patterns, a lone top bit and a lone bottom bit, so a lane swap, a reversed pair order or a flag bit leaking into the data produces a different sample. A second 8-slot run starts one slot late, with noise on the lanes and the frame line low. This places slot 0 on the other clock edge and shows that data arriving before lock is ignored. A truncated word followed by a normal word separates a resync fault from an ordinary mid-word frame fall. A word with a set pad slot separates the padding error from data loss.

// File: rtl/dlane_pkg.sv
package dlane_pkg;
  localparam int SAMPLE_W    = 12;
  localparam int PAIRS       = SAMPLE_W / 2;
  localparam int FLAG_SLOT   = PAIRS;
  localparam int SLOTS_LONG  = PAIRS + 2;
  localparam int SLOTS_SHORT = PAIRS + 1;
  localparam int CNT_W       = $clog2(SLOTS_LONG);
  localparam int EDGES       = 2;

  typedef logic [SLOTS_LONG-1:0] lane_word_t;
  typedef logic [CNT_W-1:0]      slot_cnt_t;

  // index of the final slot of a word in the selected format
  function automatic slot_cnt_t last_slot(input logic mode14);
    return mode14 ? slot_cnt_t'(SLOTS_SHORT - 1) : slot_cnt_t'(SLOTS_LONG - 1);
  endfunction

  // odd/even merge: lane A holds the upper bit of each pair
  function automatic logic [SAMPLE_W-1:0] join_lanes(input lane_word_t wa, input lane_word_t wb);
    logic [SAMPLE_W-1:0] s;
    s = '0;
    for (int k = 0; k < PAIRS; k++) begin
      s[SAMPLE_W-1-2*k] = wa[k];
      s[SAMPLE_W-2-2*k] = wb[k];
    end
    return s;
  endfunction
endpackage

// File: rtl/dlane_ddr_capture.sv
module dlane_ddr_capture #(
  parameter int W = 3
) (
  input  logic           clk,
  input  logic [W-1:0]   d_i,
  output logic [W-1:0]   early_o,
  output logic [W-1:0]   late_o
);
  logic [W-1:0] fall_q;
  logic [W-1:0] fall_hold_q;
  logic [W-1:0] rise_q;

  always_ff @(negedge clk) fall_q <= d_i;

  // retime the falling-edge slot so the pair is presented together
  always_ff @(posedge clk) begin
    fall_hold_q <= fall_q;
    rise_q      <= d_i;
  end

  assign early_o = fall_hold_q;
  assign late_o  = rise_q;
endmodule

// File: rtl/dlane_slot_step.sv
module dlane_slot_step
  import dlane_pkg::*;
(
  input  logic       mode14_i,
  input  logic       lock_i,
  input  logic       fprev_i,
  input  slot_cnt_t  cnt_i,
  input  lane_word_t wa_i,
  input  lane_word_t wb_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       f_i,
  output logic       lock_o,
  output logic       fprev_o,
  output slot_cnt_t  cnt_o,
  output lane_word_t wa_o,
  output lane_word_t wb_o,
  output logic       done_o,
  output logic       edge_err_o,
  output logic       pad_err_o
);
  logic      start;
  slot_cnt_t pos;
  slot_cnt_t last;

  always_comb begin
    start      = mode14_i ? (f_i ^ fprev_i) : (f_i & ~fprev_i);
    last       = last_slot(mode14_i);
    pos        = start ? '0 : cnt_i;
    wa_o       = wa_i;
    wb_o       = wb_i;
    wa_o[pos]  = a_i;
    wb_o[pos]  = b_i;
    lock_o     = lock_i | start;
    fprev_o    = f_i;
    cnt_o      = (pos == last) ? '0 : pos + 1'b1;
    done_o     = lock_o && (pos == last);
    edge_err_o = lock_i && start && (cnt_i != '0);
    pad_err_o  = lock_o && !mode14_i && (pos == last) && (a_i | b_i);
  end
endmodule

// File: rtl/dlane_deser.sv
module dlane_deser
  import dlane_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode14_i,
  input  logic                lane_a_i,
  input  logic                lane_b_i,
  input  logic                frame_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                dx_o,
  output logic                dy_o,
  output logic                valid_o,
  output logic                err_o
);
  localparam int PW = 3;

  logic [PW-1:0] early_w, late_w;
  logic [PW-1:0] slot_w [EDGES];

  dlane_ddr_capture #(.W(PW)) u_cap (
    .clk    (clk),
    .d_i    ({frame_i, lane_b_i, lane_a_i}),
    .early_o(early_w),
    .late_o (late_w)
  );

  assign slot_w[0] = early_w;
  assign slot_w[1] = late_w;

  logic       lock_q, fprev_q;
  slot_cnt_t  cnt_q;
  lane_word_t wa_q, wb_q;

  logic       lock_c  [EDGES+1];
  logic       fprev_c [EDGES+1];
  slot_cnt_t  cnt_c   [EDGES+1];
  lane_word_t wa_c    [EDGES+1];
  lane_word_t wb_c    [EDGES+1];
  logic [EDGES-1:0] done_w, eerr_w, perr_w;

  assign lock_c[0]  = lock_q;
  assign fprev_c[0] = fprev_q;
  assign cnt_c[0]   = cnt_q;
  assign wa_c[0]    = wa_q;
  assign wb_c[0]    = wb_q;

  for (genvar g = 0; g < EDGES; g++) begin : g_step
    dlane_slot_step u_step (
      .mode14_i  (mode14_i),
      .lock_i    (lock_c[g]),
      .fprev_i   (fprev_c[g]),
      .cnt_i     (cnt_c[g]),
      .wa_i      (wa_c[g]),
      .wb_i      (wb_c[g]),
      .a_i       (slot_w[g][0]),
      .b_i       (slot_w[g][1]),
      .f_i       (slot_w[g][2]),
      .lock_o    (lock_c[g+1]),
      .fprev_o   (fprev_c[g+1]),
      .cnt_o     (cnt_c[g+1]),
      .wa_o      (wa_c[g+1]),
      .wb_o      (wb_c[g+1]),
      .done_o    (done_w[g]),
      .edge_err_o(eerr_w[g]),
      .pad_err_o (perr_w[g])
    );
  end

  // named events for the checker
  logic       word_done_w;
  logic       fault_w;
  lane_word_t wa_sel, wb_sel;

  assign word_done_w = |done_w;
  assign fault_w     = |eerr_w | |perr_w;
  assign wa_sel      = done_w[0] ? wa_c[1] : wa_c[EDGES];
  assign wb_sel      = done_w[0] ? wb_c[1] : wb_c[EDGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      fprev_q  <= 1'b0;
      cnt_q    <= '0;
      wa_q     <= '0;
      wb_q     <= '0;
      sample_o <= '0;
      dx_o     <= 1'b0;
      dy_o     <= 1'b0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      lock_q  <= lock_c[EDGES];
      fprev_q <= fprev_c[EDGES];
      cnt_q   <= cnt_c[EDGES];
      wa_q    <= wa_c[EDGES];
      wb_q    <= wb_c[EDGES];
      valid_o <= word_done_w;
      err_o   <= fault_w;
      if (word_done_w) begin
        sample_o <= join_lanes(wa_sel, wb_sel);
        dx_o     <= wa_sel[FLAG_SLOT];
        dy_o     <= wb_sel[FLAG_SLOT];
      end
    end
  end
endmodule

// File: rtl/dlane_deser_chk.sv
module dlane_deser_chk
  import dlane_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                valid,
  input logic                err,
  input logic [SAMPLE_W-1:0] sample,
  input logic                dx,
  input logic                dy,
  input logic                locked
);
  // R6: nothing is delivered before the first word start
  a_r6_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> locked);

  // R6: lock persists until reset
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7: a word strobe lasts one clock
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R7: outputs hold between words
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(sample) && $stable(dx) && $stable(dy)));

  // R8, R9: faults are only reported once aligned
  a_r9_err_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> locked);
endmodule

bind dlane_deser dlane_deser_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .valid (valid_o),
  .err   (err_o),
  .sample(sample_o),
  .dx    (dx_o),
  .dy    (dy_o),
  .locked(lock_q)
);

// File: tb/sim_dlane_deser.sv
`timescale 1ns/1ps
module sim_dlane_deser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode14 = 1'b0;
  logic la = 1'b0, lb = 1'b0, fr = 1'b0;
  logic [11:0] sample;
  logic dx, dy, valid, err;

  always #4 clk = ~clk;

  dlane_deser u0 (
    .clk(clk), .rst_n(rst_n), .mode14_i(mode14),
    .lane_a_i(la), .lane_b_i(lb), .frame_i(fr),
    .sample_o(sample), .dx_o(dx), .dy_o(dy),
    .valid_o(valid), .err_o(err)
  );

  // {sample, dx, dy}
  localparam logic [13:0] VEC [0:7] = '{
    14'h3FFF, 14'h0000, 14'h2AAA, 14'h1555,
    14'h2000, 14'h0007, 14'h1F86, 14'h0F15
  };

  int total = 0, fails = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slot stream
  bit sa [0:511];
  bit sb [0:511];
  bit sf [0:511];
  int n = 0;

  task automatic push_slot(input bit a, input bit b, input bit f);
    sa[n] = a; sb[n] = b; sf[n] = f; n++;
  endtask

  // lane A slot k: bit 11-2k, then dx, then pad; lane B: 10-2k, dy, pad
  task automatic push_word(input bit m14, input logic [13:0] v, input bit lvl,
                           input bit pa, input bit pb, input int nslots);
    logic [11:0] s;
    s = v[13:2];
    for (int k = 0; k < nslots; k++) begin
      bit a, b, f;
      if (k < 6) begin a = s[11-2*k]; b = s[10-2*k]; end
      else if (k == 6) begin a = v[1]; b = v[0]; end
      else begin a = pa; b = pb; end
      f = m14 ? lvl : (k < 4);
      push_slot(a, b, f);
    end
  endtask

  task automatic send_stream();
    bit lastf;
    lastf = (n > 0) ? sf[n-1] : 1'b0;
    if (n % 2) push_slot(0, 0, lastf);
    for (int i = 0; i < 4; i++) push_slot(0, 0, lastf);
    for (int i = 0; i < n; i += 2) begin
      @(posedge clk); #1;
      la = sa[i]; lb = sb[i]; fr = sf[i];
      @(negedge clk); #1;
      la = sa[i+1]; lb = sb[i+1]; fr = sf[i+1];
    end
  endtask

  // monitor
  logic [13:0] cap [0:63];
  int cap_n = 0, err_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (cap_n < 64) cap[cap_n] = {sample, dx, dy};
        cap_n++;
      end
      if (err) err_n++;
    end
  end

  task automatic do_reset(input bit m14);
    @(posedge clk); #1;
    rst_n = 1'b0; la = 0; lb = 0; fr = 0; mode14 = m14;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid === 1'b0 && err === 1'b0, "R10", "valid/err in reset", {valid, err}, 0);
    check(sample === 12'h000 && dx === 1'b0 && dy === 1'b0, "R10", "data in reset",
          {sample, dx, dy}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cap_n = 0; err_n = 0; n = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // table walk in both formats: R1 R2 R3 R4 R7
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      push_slot(0, 0, 0); push_slot(0, 0, 0);
      for (int i = 0; i < 8; i++) push_word(m[0], VEC[i], ~i[0], 0, 0, m ? 7 : 8);
      send_stream();
      @(negedge clk);
      check(cap_n == 8, m ? "R4" : "R3", "word count", cap_n, 8);
      check(err_n == 0, "R7", "no fault", err_n, 0);
      for (int i = 0; i < 8; i++)
        check(cap[i] == VEC[i], "R1", $sformatf("word %0d mode %0d (R2 flags)", i, m),
              cap[i], VEC[i]);
    end

    // R5 R6: odd lead-in with noisy lanes before first frame rise
    do_reset(1'b0);
    push_slot(1, 1, 0); push_slot(1, 0, 0); push_slot(0, 1, 0);
    push_slot(1, 1, 0); push_slot(1, 1, 0);
    push_word(0, VEC[2], 0, 0, 0, 8);
    push_word(0, VEC[7], 0, 0, 0, 8);
    send_stream();
    @(negedge clk);
    check(cap_n == 2, "R6", "words after noisy lead-in", cap_n, 2);
    check(err_n == 0, "R6", "no fault before lock", err_n, 0);
    check(cap[0] == VEC[2], "R5", "word on opposite edge", cap[0], VEC[2]);
    check(cap[1] == VEC[7], "R5", "second word on opposite edge", cap[1], VEC[7]);

    // R9: truncated word then resync (8-slot format)
    do_reset(1'b0);
    push_slot(0, 0, 0); push_slot(0, 0, 0);
    push_word(0, VEC[6], 0, 0, 0, 8);
    push_word(0, VEC[0], 0, 0, 0, 5);
    push_word(0, VEC[3], 0, 0, 0, 8);
    push_word(0, VEC[5], 0, 0, 0, 8);
    send_stream();
    @(negedge clk);
    check(err_n == 1, "R9", "early edge fault count", err_n, 1);
    check(cap_n == 3, "R9", "partial word dropped", cap_n, 3);
    check(cap[1] == VEC[3], "R9", "word after resync", cap[1], VEC[3]);
    check(cap[2] == VEC[5], "R9", "following word", cap[2], VEC[5]);

    // R9: truncated word in 7-slot format
    do_reset(1'b1);
    push_slot(0, 0, 0); push_slot(0, 0, 0);
    push_word(1, VEC[4], 1, 0, 0, 7);
    push_word(1, VEC[1], 0, 0, 0, 3);
    push_word(1, VEC[2], 1, 0, 0, 7);
    send_stream();
    @(negedge clk);
    check(err_n == 1 && cap_n == 2, "R9", "7-slot resync fault/words", {err_n, cap_n}, 'h12);
    check(cap[1] == VEC[2], "R9", "7-slot word after resync", cap[1], VEC[2]);

    // R8: nonzero pad still delivers the word
    do_reset(1'b0);
    push_slot(0, 0, 0); push_slot(0, 0, 0);
    push_word(0, VEC[7], 0, 1, 0, 8);
    push_word(0, VEC[6], 0, 0, 1, 8);
    push_word(0, VEC[1], 0, 0, 0, 8);
    send_stream();
    @(negedge clk);
    check(err_n == 2, "R8", "pad fault count", err_n, 2);
    check(cap_n == 3 && cap[0] == VEC[7], "R8", "word with set pad", cap[0], VEC[7]);
    check(cap[1] == VEC[6], "R8", "second padded word", cap[1], VEC[6]);

    // R10: reset mid-stream clears outputs
    do_reset(1'b0);
    finish_run();
  end
endmodule